// File: doc/BRIEF.md
# Decimated Sample Output Formatter

This block sits after a decimating channel filter and turns each complex baseband sample pair (I and Q) into one output word format chosen by a static control field. There is one floating-point format and four two's complement widths, and each width has its own rounding or truncation rule. The formatted pair is latched together. It is then offered on two ports at the same time: a bit-serial port with its own serial clock, frame sync and ready strobe, and a 16-bit parallel port whose lines carry the part of the latched pair picked by a 3-bit select.

The serial clock runs at half the core clock. Each serial slot lasts two core cycles, low half first. A word takes one frame-sync slot followed by its data bits, MSB first, and I is sent before Q. Ready goes active when a new pair has been latched. It drops once the serial port has finished sending the pair, or when the parallel reader strobes a read. The serial clock, frame sync and ready lines can each be inverted by a control bit.

Top module: `sample_out_formatter`

## Requirements
- R1: After reset, ready is inactive, the serial clock and frame sync sit at their idle levels, serial data is 0 and every parallel select reads 0.
- R2: With format code 0, each sample is normalised by shifting left until its top two bits differ, with the shift count capped at 15. The word is {zeros, shift[3:0] in bits 11:8, top 8 bits of the shifted sample in bits 7:0}, and it is 12 bits long on the serial port.
- R3: With format code 0 and exponent inhibit set, bits 11:8 are 0 and bits 7:0 are the top 8 bits of the unshifted sample.
- R4: Format code 1 gives the top 8 input bits, truncated. Codes 4 to 7 give the top 32 bits unchanged. Every two's complement word is sign-extended to 32 bits for the parallel port.
- R5: Format codes 2 and 3 give the top 16 and top 24 bits, rounded half up on the next lower bit. A round-up past the largest positive code saturates there, so a non-negative sample never yields a negative word.
- R6: Serial word lengths are 12, 8, 16, 24 and 32 bits for codes 0, 1, 2, 3 and 4 to 7.
- R7: When the parallel enable is high, select 0 shows I[15:0], 1 shows I[31:16], 2 shows Q[15:0], 3 shows Q[31:16] and 4 shows {I[7:0], Q[7:0]}. Selects 5 to 7 and a low enable show 0.
- R8: With the serial port enabled, a latch starts a frame on the next cycle. Each slot is two cycles with the clock low then high. Per word, slot 0 asserts frame sync with data 0, and slots 1 to L carry bits L-1 down to 0. I is sent, then Q.
- R9: The clock, frame-sync and ready outputs are each XORed with their own inversion bit. Serial data is never inverted.
- R10: Ready goes active in the cycle after a valid sample. It goes inactive after the last serial slot of Q, or after a read strobe. A valid sample in the same cycle as either of these keeps ready active.
- R11: With the serial port disabled, the serial clock and frame sync stay idle and data stays 0. Ready is then cleared only by a read strobe.
- R12: A valid sample that arrives while a frame is in progress latches the new pair and restarts the frame from the frame-sync slot of I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample pair strobe |
| in_i | input | IN_W | In-phase sample, signed |
| in_q | input | IN_W | Quadrature sample, signed |
| fmt_sel | input | 3 | Output format code |
| exp_inhibit | input | 1 | Force the floating-point exponent to zero |
| ser_en | input | 1 | Serial port enable |
| sclk_inv | input | 1 | Serial clock inversion |
| sfs_inv | input | 1 | Frame sync inversion |
| rdy_inv | input | 1 | Ready inversion |
| par_sel | input | 3 | Parallel word select |
| par_oe | input | 1 | Parallel output enable |
| par_rd | input | 1 | Parallel read strobe, clears ready |
| ser_clk | output | 1 | Serial clock |
| ser_fs | output | 1 | Serial frame sync |
| ser_data | output | 1 | Serial data |
| rdy | output | 1 | Ready |
| par_data | output | 16 | Parallel data |

## Verification
Some properties are checked on every cycle. Ready may only rise after a valid sample and may only fall after a completed frame or a read. While a frame runs, the serial clock toggles every cycle and no slot count passes the latched word length. A disabled port is quiet. Truncated words keep the sign of the input, a non-negative sample never gives a negative word, and an inhibited exponent is zero. Other behaviour needs the bench's scenarios: the exact normalisation and rounding values at half-way points and saturation, the bit order and slot timing of whole frames, the polarity inversions, the parallel select map, and a restart in the middle of a frame.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LEN_W  = $clog2(WORD_W) + 1;

  typedef enum logic [2:0] {
    FMT_FLT12 = 3'd0,
    FMT_TRC8  = 3'd1,
    FMT_RND16 = 3'd2,
    FMT_RND24 = 3'd3,
    FMT_TRC32 = 3'd4
  } fmt_e;

  // serial word length for a format code (codes above 4 behave as 32-bit)
  function automatic logic [LEN_W-1:0] word_len(input logic [2:0] code);
    case (code)
      3'd0:    word_len = LEN_W'(12);
      3'd1:    word_len = LEN_W'(8);
      3'd2:    word_len = LEN_W'(16);
      3'd3:    word_len = LEN_W'(24);
      default: word_len = LEN_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/ofmt_round.sv
module ofmt_round #(
  parameter int IN_W = 32,
  parameter int KEEP = 16
) (
  input  logic [IN_W-1:0] x,
  output logic [KEEP-1:0] y
);
  localparam logic [KEEP-1:0] MAX_POS = {1'b0, {(KEEP-1){1'b1}}};

  logic [KEEP-1:0] top;
  logic            half;

  always_comb begin
    top  = x[IN_W-1 -: KEEP];
    half = x[IN_W-1-KEEP];
    if ((top == MAX_POS) && half) y = MAX_POS;
    else                          y = top + KEEP'(half);
  end
endmodule

// File: rtl/ofmt_lane_conv.sv
module ofmt_lane_conv
  import ofmt_pkg::*;
#(
  parameter int IN_W = 32
) (
  input  logic [IN_W-1:0]   smp,
  input  logic [2:0]        fmt,
  input  logic              exp_inh,
  output logic [WORD_W-1:0] word
);
  localparam int LEAD_W = $clog2(IN_W);

  logic [LEAD_W-1:0] lead;
  logic [3:0]        shamt;
  logic [IN_W-1:0]   normed;
  logic [15:0]       rnd16;
  logic [23:0]       rnd24;

  // count bits below the MSB that repeat the sign
  always_comb begin
    logic run;
    run  = 1'b1;
    lead = '0;
    for (int b = IN_W - 2; b >= 0; b--) begin
      if (run && (smp[b] == smp[IN_W-1])) lead = lead + LEAD_W'(1);
      else                                run  = 1'b0;
    end
  end

  always_comb begin
    if (exp_inh)                   shamt = 4'd0;
    else if (lead > LEAD_W'(15))   shamt = 4'd15;
    else                           shamt = lead[3:0];
    normed = smp << shamt;
  end

  ofmt_round #(.IN_W(IN_W), .KEEP(16)) u_rnd16 (.x(smp), .y(rnd16));
  ofmt_round #(.IN_W(IN_W), .KEEP(24)) u_rnd24 (.x(smp), .y(rnd24));

  always_comb begin
    case (fmt)
      FMT_FLT12: word = {{(WORD_W-12){1'b0}}, shamt, normed[IN_W-1 -: 8]};
      FMT_TRC8:  word = {{(WORD_W-8){smp[IN_W-1]}}, smp[IN_W-1 -: 8]};
      FMT_RND16: word = {{(WORD_W-16){rnd16[15]}}, rnd16};
      FMT_RND24: word = {{(WORD_W-24){rnd24[23]}}, rnd24};
      default:   word = smp[IN_W-1 -: WORD_W];
    endcase
  end
endmodule

// File: rtl/ofmt_serializer.sv
module ofmt_serializer
  import ofmt_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   start_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [1:0][WORD_W-1:0] words_i,
  output logic                   sclk_o,
  output logic                   sfs_o,
  output logic                   sdata_o,
  output logic                   done_o
);
  localparam int IDX_W = $clog2(WORD_W);

  logic             busy_q, busy_d;
  logic             ph_q, ph_d;
  logic             wsel_q, wsel_d;
  logic [LEN_W-1:0] slot_q, slot_d;
  logic [LEN_W-1:0] bidx;
  logic             last;

  assign last = busy_q && ph_q && wsel_q && (slot_q == len_i);

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    wsel_d = wsel_q;
    slot_d = slot_q;
    if (!en_i) begin
      busy_d = 1'b0;
      ph_d   = 1'b0;
      wsel_d = 1'b0;
      slot_d = '0;
    end else if (start_i) begin
      busy_d = 1'b1;
      ph_d   = 1'b0;
      wsel_d = 1'b0;
      slot_d = '0;
    end else if (busy_q) begin
      ph_d = ~ph_q;
      if (ph_q) begin
        if (slot_q == len_i) begin
          slot_d = '0;
          wsel_d = ~wsel_q;
          if (wsel_q) busy_d = 1'b0;
        end else begin
          slot_d = slot_q + LEN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      wsel_q <= 1'b0;
      slot_q <= '0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      wsel_q <= wsel_d;
      slot_q <= slot_d;
    end
  end

  always_comb begin
    bidx    = len_i - slot_q;
    sclk_o  = busy_q && ph_q;
    sfs_o   = busy_q && (slot_q == '0);
    sdata_o = (busy_q && (slot_q != '0)) ? words_i[wsel_q][bidx[IDX_W-1:0]] : 1'b0;
    done_o  = last && en_i;
  end

  // R8: the serial clock alternates every cycle inside a running frame
  assert_sclk_toggles_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && en_i && !start_i && !last) |=> (sclk_o != $past(sclk_o)));

  // R8: the slot counter never passes the latched word length
  assert_slot_in_range_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_q |-> (slot_q <= len_i));

  // R8: frame sync lasts a whole slot (both clock halves)
  assert_fs_full_slot_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(sfs_o) && en_i) |=> sfs_o);
endmodule

// File: rtl/ofmt_par_mux.sv
module ofmt_par_mux
  import ofmt_pkg::*;
(
  input  logic [1:0][WORD_W-1:0] words_i,
  input  logic [2:0]             sel_i,
  input  logic                   oe_i,
  output logic [15:0]            data_o
);
  always_comb begin
    data_o = 16'h0000;
    if (oe_i) begin
      case (sel_i)
        3'd0:    data_o = words_i[0][15:0];
        3'd1:    data_o = words_i[0][31:16];
        3'd2:    data_o = words_i[1][15:0];
        3'd3:    data_o = words_i[1][31:16];
        3'd4:    data_o = {words_i[0][7:0], words_i[1][7:0]};
        default: data_o = 16'h0000;
      endcase
    end
  end
endmodule

// File: rtl/sample_out_formatter.sv
module sample_out_formatter
  import ofmt_pkg::*;
#(
  parameter int IN_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_i,
  input  logic [IN_W-1:0] in_q,
  input  logic [2:0]      fmt_sel,
  input  logic            exp_inhibit,
  input  logic            ser_en,
  input  logic            sclk_inv,
  input  logic            sfs_inv,
  input  logic            rdy_inv,
  input  logic [2:0]      par_sel,
  input  logic            par_oe,
  input  logic            par_rd,
  output logic            ser_clk,
  output logic            ser_fs,
  output logic            ser_data,
  output logic            rdy,
  output logic [15:0]     par_data
);
  localparam int LANES = 2;

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [LANES-1:0][IN_W-1:0]   lane_in;
  logic [LANES-1:0][WORD_W-1:0] lane_word;
  logic [LANES-1:0][WORD_W-1:0] word_q, word_d;
  logic [LEN_W-1:0]             len_q, len_d;
  logic                         rdy_q, rdy_d;
  logic                         ser_sclk, ser_fs_i, ser_done;

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ofmt_lane_conv #(.IN_W(IN_W)) u_conv (
      .smp     (lane_in[g]),
      .fmt     (fmt_sel),
      .exp_inh (exp_inhibit),
      .word    (lane_word[g])
    );
  end

  always_comb begin
    word_d = word_q;
    len_d  = len_q;
    if (in_valid) begin
      word_d = lane_word;
      len_d  = word_len(fmt_sel);
    end
    if (in_valid)                 rdy_d = 1'b1;
    else if (ser_done || par_rd)  rdy_d = 1'b0;
    else                          rdy_d = rdy_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      len_q  <= '0;
      rdy_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      len_q  <= len_d;
      rdy_q  <= rdy_d;
    end
  end

  ofmt_serializer u_ser (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .en_i    (ser_en),
    .start_i (in_valid),
    .len_i   (len_q),
    .words_i (word_q),
    .sclk_o  (ser_sclk),
    .sfs_o   (ser_fs_i),
    .sdata_o (ser_data),
    .done_o  (ser_done)
  );

  ofmt_par_mux u_par (
    .words_i (word_q),
    .sel_i   (par_sel),
    .oe_i    (par_oe),
    .data_o  (par_data)
  );

  assign ser_clk = ser_sclk ^ sclk_inv;
  assign ser_fs  = ser_fs_i ^ sfs_inv;
  assign rdy     = rdy_q ^ rdy_inv;

  // R10: ready only rises after a valid sample
  assert_rdy_rise_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rdy_q) |-> $past(in_valid));

  // R10: ready only falls after a finished frame or a read
  assert_rdy_fall_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(rdy_q) |-> ($past(ser_done) || $past(par_rd)));

  // R4: truncated formats keep the input sign
  assert_trunc_sign_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && (fmt_sel == FMT_TRC8 || fmt_sel[2]))
      |=> (word_q[0][WORD_W-1] == $past(in_i[IN_W-1])));

  // R5: a non-negative sample never becomes a negative word
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && !in_q[IN_W-1]) |=> !word_q[1][WORD_W-1]);

  // R3: inhibited exponent field is zero
  assert_exp_zero_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && fmt_sel == FMT_FLT12 && exp_inhibit) |=> (word_q[0][11:8] == 4'd0));

  // R11: a disabled serial port stays quiet
  assert_ser_quiet_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    !ser_en |=> (!ser_sclk && !ser_fs_i && !ser_data));
endmodule

// File: tb/sample_out_formatter_tb.sv
module sample_out_formatter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_i = '0, in_q = '0;
  logic [2:0]  fmt_sel = 3'd4;
  logic        exp_inhibit = 1'b0, ser_en = 1'b1;
  logic        sclk_inv = 1'b0, sfs_inv = 1'b0, rdy_inv = 1'b0;
  logic [2:0]  par_sel = 3'd0;
  logic        par_oe = 1'b1, par_rd = 1'b0;
  logic        ser_clk, ser_fs, ser_data, rdy;
  logic [15:0] par_data;

  int errors = 0;
  int checks = 0;
  bit cyc_on = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sample_out_formatter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .fmt_sel(fmt_sel), .exp_inhibit(exp_inhibit), .ser_en(ser_en),
    .sclk_inv(sclk_inv), .sfs_inv(sfs_inv), .rdy_inv(rdy_inv),
    .par_sel(par_sel), .par_oe(par_oe), .par_rd(par_rd),
    .ser_clk(ser_clk), .ser_fs(ser_fs), .ser_data(ser_data), .rdy(rdy),
    .par_data(par_data)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic [31:0] fmt_ref(input logic [31:0] x, input int f, input bit inh);
    longint v;
    logic [31:0] s;
    int n;
    case (f)
      0: begin
        s = x; n = 0;
        if (!inh) while (n < 15 && s[31] == s[30]) begin s = s << 1; n++; end
        return {20'd0, 4'(n), s[31:24]};
      end
      1: return {{24{x[31]}}, x[31:24]};
      2: begin
        v = (longint'($signed(x)) >>> 16) + longint'(x[15]);
        if (v > 32767) v = 32767;
        return 32'(v);
      end
      3: begin
        v = (longint'($signed(x)) >>> 8) + longint'(x[7]);
        if (v > 8388607) v = 8388607;
        return 32'(v);
      end
      default: return x;
    endcase
  endfunction

  function automatic int len_ref(input int f);
    case (f)
      0: return 12; 1: return 8; 2: return 16; 3: return 24;
      default: return 32;
    endcase
  endfunction

  logic [31:0] m_i = '0, m_q = '0;
  int m_len = 32;
  int m_t = -1;
  bit m_rdy = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_i = '0; m_q = '0; m_t = -1; m_rdy = 1'b0;
    end else if (in_valid) begin
      m_i = fmt_ref(in_i, int'(fmt_sel), exp_inhibit);
      m_q = fmt_ref(in_q, int'(fmt_sel), exp_inhibit);
      m_len = len_ref(int'(fmt_sel));
      m_t = ser_en ? 0 : -1;
      m_rdy = 1'b1;
    end else begin
      if (m_t >= 0) begin
        m_t++;
        if (m_t == 4 * (m_len + 1)) begin m_t = -1; m_rdy = 1'b0; end
      end
      if (par_rd) m_rdy = 1'b0;
    end
  end

  function automatic logic [15:0] par_ref(input int sel, input bit oe);
    if (!oe) return 16'h0;
    case (sel)
      0: return m_i[15:0];
      1: return m_i[31:16];
      2: return m_q[15:0];
      3: return m_q[31:16];
      4: return {m_i[7:0], m_q[7:0]};
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference (R8 R9 R10 R7)
  always @(negedge clk) begin
    if (cyc_on) begin
      bit e_clk, e_fs, e_d;
      int slot, k;
      e_clk = 0; e_fs = 0; e_d = 0;
      if (m_t >= 0) begin
        slot = m_t / 2;
        k = slot % (m_len + 1);
        e_clk = (m_t % 2) == 1;
        e_fs = (k == 0);
        if (k != 0) e_d = (slot / (m_len + 1) == 0) ? m_i[m_len - k] : m_q[m_len - k];
      end
      chk("R8/R9 ser_clk", 32'(ser_clk), 32'(e_clk ^ sclk_inv));
      chk("R8/R9 ser_fs", 32'(ser_fs), 32'(e_fs ^ sfs_inv));
      chk("R8 ser_data", 32'(ser_data), 32'(e_d));
      chk("R10/R9 rdy", 32'(rdy), 32'(m_rdy ^ rdy_inv));
      chk("R7 par_data", 32'(par_data), 32'(par_ref(int'(par_sel), par_oe)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [31:0] i, input logic [31:0] q);
    step(); in_valid = 1'b1; in_i = i; in_q = q;
    step(); in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_t >= 0) step();
    step();
  endtask

  task automatic read_word(input int lane, output logic [31:0] w);
    step(); par_sel = 3'(lane * 2 + 1);
    @(negedge clk); w[31:16] = par_data;
    step(); par_sel = 3'(lane * 2);
    @(negedge clk); w[15:0] = par_data;
  endtask

  task automatic fmt_case(input string req, input int f, input bit inh,
                          input logic [31:0] i, input logic [31:0] q,
                          input logic [31:0] ei, input logic [31:0] eq);
    logic [31:0] w;
    step(); fmt_sel = 3'(f); exp_inhibit = inh;
    send(i, q);
    read_word(0, w); chk({req, " I word"}, w, ei);
    read_word(1, w); chk({req, " Q word"}, w, eq);
    wait_idle();
  endtask

  initial begin
    logic [31:0] w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();
    // R1: reset state at the ports
    @(negedge clk);
    chk("R1 rdy", 32'(rdy), 32'h0);
    chk("R1 ser_clk", 32'(ser_clk), 32'h0);
    chk("R1 ser_fs", 32'(ser_fs), 32'h0);
    chk("R1 ser_data", 32'(ser_data), 32'h0);
    chk("R1 par_data", 32'(par_data), 32'h0);
    cyc_on = 1'b1;

    // R4 R6: 32-bit pass-through, full frame compared every cycle
    fmt_case("R4 t32", 4, 0, 32'hA5C3_0F96, 32'h1234_5678, 32'hA5C3_0F96, 32'h1234_5678);
    // R2: normalisation, saturation at 15, negative
    fmt_case("R2 flt", 0, 0, 32'h0000_0000, 32'h0040_0000, 32'h0000_0F00, 32'h0000_0840);
    fmt_case("R2 flt", 0, 0, 32'h8000_0000, 32'h1234_5678, 32'h0000_0080, 32'h0000_0248);
    // R3: inhibited exponent
    fmt_case("R3 inh", 0, 1, 32'h1234_5678, 32'h0040_0000, 32'h0000_0012, 32'h0000_0000);
    // R5: 16-bit rounding, half up, saturation, negatives
    fmt_case("R5 r16", 2, 0, 32'h0001_8000, 32'h7FFF_8000, 32'h0000_0002, 32'h0000_7FFF);
    fmt_case("R5 r16", 2, 0, 32'hFFFF_8000, 32'hFFFE_8000, 32'h0000_0000, 32'hFFFF_FFFF);
    fmt_case("R5 r16", 2, 0, 32'h1234_7FFF, 32'h8000_0000, 32'h0000_1234, 32'hFFFF_8000);
    // R5: 24-bit rounding
    fmt_case("R5 r24", 3, 0, 32'h7FFF_FF80, 32'h1234_5680, 32'h007F_FFFF, 32'h0012_3457);
    // R4: 8-bit truncation, sign extension
    fmt_case("R4 t8", 1, 0, 32'hABCD_EF12, 32'h7FFF_FFFF, 32'hFFFF_FFAB, 32'h0000_007F);
    // R6: codes 5..7 act as 32-bit
    fmt_case("R6 code7", 7, 0, 32'h0BAD_F00D, 32'hFEED_0001, 32'h0BAD_F00D, 32'hFEED_0001);

    // R7: packed select, unused select, output disabled
    step(); par_sel = 3'd4; @(negedge clk);
    chk("R7 sel4", 32'(par_data), 32'h0000_0D01);
    step(); par_sel = 3'd6; @(negedge clk);
    chk("R7 sel6", 32'(par_data), 32'h0);
    step(); par_sel = 3'd0; par_oe = 1'b0; @(negedge clk);
    chk("R7 oe low", 32'(par_data), 32'h0);
    step(); par_oe = 1'b1;

    // R9: all three strobes inverted for a full frame
    step(); sclk_inv = 1'b1; sfs_inv = 1'b1; rdy_inv = 1'b1; fmt_sel = 3'd1;
    step(); @(negedge clk);
    chk("R9 idle inverted", {29'd0, ser_clk, ser_fs, rdy}, 32'h7);
    send(32'h5A00_0000, 32'hC300_0000);
    wait_idle();
    step(); sclk_inv = 1'b0; sfs_inv = 1'b0; rdy_inv = 1'b0;

    // R12: a new pair restarts the frame midway
    step(); fmt_sel = 3'd2;
    send(32'h1111_0000, 32'h2222_0000);
    repeat (23) step();
    send(32'h3333_0000, 32'h4444_0000);
    read_word(0, w); chk("R12 new I", w, 32'h0000_3333);
    wait_idle();

    // R11 R10: serial disabled, ready cleared only by a read
    step(); ser_en = 1'b0;
    send(32'h0F0F_0000, 32'h0000_0000);
    repeat (40) step();
    @(negedge clk);
    chk("R11 rdy held", 32'(rdy), 32'h1);
    chk("R11 quiet", {30'd0, ser_clk, ser_fs}, 32'h0);
    step(); par_rd = 1'b1;
    step(); par_rd = 1'b0;
    @(negedge clk);
    chk("R10 read clears", 32'(rdy), 32'h0);
    // R10: valid and read together keep ready
    step(); in_valid = 1'b1; par_rd = 1'b1; in_i = 32'h0100_0000;
    step(); in_valid = 1'b0; par_rd = 1'b0;
    @(negedge clk);
    chk("R10 valid wins", 32'(rdy), 32'h1);
    step(); ser_en = 1'b1;
    repeat (4) step();

    cyc_on = 1'b0;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule